// File: doc/BRIEF.md
# SDRAM Bank State and Command Legality Tracker

This block watches the command bus between a memory controller and a four-bank single-data-rate SDRAM. Every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable lines, the clock-enable line, address bit 10, the two bank-select bits and the write data mask. From these it keeps a record of which banks hold an open row and how long each bank still has to recover after a precharge.

It flags three kinds of protocol fault. The first is a column access to a bank with no open row. The second is a row activation that arrives before the precharge recovery time has run out. The third is a power-down that lasts longer than the refresh period. It also reports whether the device is in power-down and what kind of power-down it is. For write bursts it produces a per-beat indication that a data element was actually committed. That indication takes into account the data mask and early termination of the burst.

The tracker only observes the bus and drives nothing back onto it. A controller or a bus monitor uses its outputs as status or as error indications.

Top module: `sdr_bank_tracker`

## Requirements
- R1: Commands are decoded from (cs_n, ras_n, cas_n, we_n). cs_n=1 is inhibit, 0111 is NOP, 0011 is ACTIVE, 0101 is READ, 0100 is WRITE, 0110 is BURST TERMINATE and 0010 is PRECHARGE. Any other pattern changes no state tracked here.
- R2: A synchronous active-high reset leaves every bank closed and ready, power-down off, and every flag and wr_commit low.
- R3: An ACTIVE to a closed bank whose recovery count has expired sets that bank's bit in bank_open after the sampling edge.
- R4: A PRECHARGE with a10=1 clears every bit of bank_open, whatever the value of ba.
- R5: A PRECHARGE with a10=0 clears only bank_open[ba].
- R6: A READ or WRITE to a bank whose bank_open bit is 0 raises err_idle_access for exactly one cycle. The same command to an open bank does not raise it.
- R7: After a PRECHARGE, an ACTIVE to an affected bank fewer than TRP cycles later raises err_early_act for one cycle and leaves the bank closed. An ACTIVE exactly TRP cycles later is accepted.
- R8: Power-down (pd_on=1) begins when cke is sampled low with a NOP or inhibit while no write burst is in progress. While pd_on is 1, commands have no effect on banks, flags or wr_commit.
- R9: pd_active_kind is 1 when some bank was open at power-down entry and 0 when all banks were closed.
- R10: Power-down ends at the first edge where cke is sampled high. pd_on then clears and bank_open keeps its value.
- R11: err_pd_overlong rises once power-down has lasted more than CLK_MHZ*REFRESH_US cycles. It clears when power-down ends.
- R12: A WRITE to an open bank starts a burst of BURST_LEN beats, the first beat being the WRITE cycle. wr_commit is high in the cycle after each beat sampled with dqm=0.
- R13: A BURST TERMINATE during a write burst commits nothing in its own cycle and ends the burst. Any other command except NOP or inhibit also ends the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| a10 | input | 1 | Address bit 10 (all-bank precharge select) |
| ba | input | 2 | Bank select |
| dqm | input | 1 | Write data mask for the current beat |
| bank_open | output | 4 | One bit per bank, 1 when a row is open |
| pd_on | output | 1 | Device is in power-down |
| pd_active_kind | output | 1 | 1 for active power-down, 0 for precharge power-down |
| wr_commit | output | 1 | Previous cycle's write beat was committed |
| err_idle_access | output | 1 | Column access to a closed bank (one-cycle pulse) |
| err_early_act | output | 1 | ACTIVE before precharge recovery ended (one-cycle pulse) |
| err_pd_overlong | output | 1 | Power-down exceeded the refresh period |

## Verification
The assertions assume that the command lines carry known values at every sampled edge. They also assume that cke is not raised and lowered in a way that hides a command from the power-down rules, because during power-down every command is treated as ignored. The directed stimulus drives all inputs on the falling edge, keeps every line defined after reset, and issues commands only through a single stepping task. This gives one well-formed command per cycle. The refresh limit is shortened through REFRESH_US so that the over-long power-down boundary can be reached in about a hundred cycles.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

    typedef enum logic [2:0] {
        CMD_INH,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_BST,
        CMD_PRE,
        CMD_OTHER
    } sdr_cmd_e;

    // R1: control-line decode
    function automatic sdr_cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                            input logic cas_n, input logic we_n);
        sdr_cmd_e c;
        if (cs_n) begin
            c = CMD_INH;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  c = CMD_NOP;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b110:  c = CMD_BST;
                3'b010:  c = CMD_PRE;
                default: c = CMD_OTHER;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sdr_bank_slot.sv
module sdr_bank_slot #(
    parameter int TRP = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic open_req,
    input  logic close_req,
    output logic is_open,
    output logic ready
);
    localparam int CW = (TRP < 2) ? 1 : $clog2(TRP);
    localparam logic [CW-1:0] RELOAD = CW'(TRP - 1);

    typedef struct packed {
        logic          open;
        logic [CW-1:0] cnt;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.cnt != '0) begin
            slot_d.cnt = slot_q.cnt - 1'b1;
        end
        if (close_req) begin
            slot_d.open = 1'b0;
            slot_d.cnt  = RELOAD;
        end else if (open_req) begin
            slot_d.open = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign is_open = slot_q.open;
    assign ready   = (slot_q.cnt == '0);
endmodule

// File: rtl/sdr_pd_monitor.sv
module sdr_pd_monitor #(
    parameter int PD_LIMIT = 6400000
) (
    input  logic clk,
    input  logic rst,
    input  logic enter_req,
    input  logic cke,
    input  logic any_open,
    output logic pd_on,
    output logic pd_kind,
    output logic overlong
);
    localparam int CW = $clog2(PD_LIMIT + 2);
    localparam logic [CW-1:0] LIM = CW'(PD_LIMIT);

    typedef struct packed {
        logic          on;
        logic          kind;
        logic          over;
        logic [CW-1:0] cnt;
    } pd_t;

    pd_t pd_d, pd_q;

    always_comb begin
        pd_d = pd_q;
        if (!pd_q.on) begin
            if (enter_req) begin
                pd_d.on   = 1'b1;
                pd_d.kind = any_open;
                pd_d.cnt  = CW'(1);
            end
        end else if (cke) begin
            pd_d = '0;
        end else begin
            if (pd_q.cnt <= LIM) begin
                pd_d.cnt = pd_q.cnt + 1'b1;
            end
        end
        pd_d.over = pd_d.on && (pd_d.cnt > LIM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q <= '0;
        end else begin
            pd_q <= pd_d;
        end
    end

    assign pd_on    = pd_q.on;
    assign pd_kind  = pd_q.kind;
    assign overlong = pd_q.over;
endmodule

// File: rtl/sdr_wr_burst.sv
module sdr_wr_burst
    import sdr_trk_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  sdr_cmd_e cmd,
    input  logic     start,
    input  logic     dqm,
    output logic     commit,
    output logic     busy
);
    localparam int RW = $clog2(BURST_LEN + 1);
    localparam logic [RW-1:0] FIRST_REM = RW'(BURST_LEN - 1);

    typedef struct packed {
        logic          commit;
        logic [RW-1:0] rem;
    } wb_t;

    wb_t wb_d, wb_q;

    always_comb begin
        wb_d        = wb_q;
        wb_d.commit = 1'b0;
        if (start) begin
            wb_d.commit = !dqm;
            wb_d.rem    = FIRST_REM;
        end else if (wb_q.rem != '0) begin
            if (cmd == CMD_NOP || cmd == CMD_INH) begin
                wb_d.commit = !dqm;
                wb_d.rem    = wb_q.rem - 1'b1;
            end else begin
                wb_d.rem = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q <= '0;
        end else begin
            wb_q <= wb_d;
        end
    end

    assign commit = wb_q.commit;
    assign busy   = (wb_q.rem != '0);
endmodule

// File: rtl/sdr_bank_tracker.sv
module sdr_bank_tracker
    import sdr_trk_pkg::*;
#(
    parameter int TRP        = 3,
    parameter int BURST_LEN  = 4,
    parameter int CLK_MHZ    = 100,
    parameter int REFRESH_US = 64000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       cke,
    input  logic       a10,
    input  logic [1:0] ba,
    input  logic       dqm,
    output logic [3:0] bank_open,
    output logic       pd_on,
    output logic       pd_active_kind,
    output logic       wr_commit,
    output logic       err_idle_access,
    output logic       err_early_act,
    output logic       err_pd_overlong
);
    localparam int NB       = 4;
    localparam int PD_LIMIT = CLK_MHZ * REFRESH_US;

    typedef struct packed {
        logic idle;
        logic early;
    } err_t;

    sdr_cmd_e cmd_raw, cmd;
    logic [NB-1:0] ready, open_req, close_req;
    logic          wr_start, wr_busy, pd_enter;
    err_t          err_d, err_q;

    assign cmd_raw = decode_cmd(cs_n, ras_n, cas_n, we_n);
    assign cmd     = pd_on ? CMD_INH : cmd_raw;

    for (genvar i = 0; i < NB; i++) begin : g_bank
        logic hit;
        assign hit          = (ba == i[1:0]);
        assign open_req[i]  = (cmd == CMD_ACT) && hit && ready[i] && !bank_open[i];
        assign close_req[i] = (cmd == CMD_PRE) && (a10 || hit);

        sdr_bank_slot #(.TRP(TRP)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .open_req (open_req[i]),
            .close_req(close_req[i]),
            .is_open  (bank_open[i]),
            .ready    (ready[i])
        );
    end

    assign wr_start = (cmd == CMD_WR) && bank_open[ba];
    assign pd_enter = !pd_on && !cke && !wr_busy
                      && (cmd_raw == CMD_NOP || cmd_raw == CMD_INH);

    always_comb begin
        err_d       = '0;
        err_d.idle  = (cmd == CMD_RD || cmd == CMD_WR) && !bank_open[ba];
        err_d.early = (cmd == CMD_ACT) && !ready[ba];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    sdr_wr_burst #(.BURST_LEN(BURST_LEN)) u_wr (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .start (wr_start),
        .dqm   (dqm),
        .commit(wr_commit),
        .busy  (wr_busy)
    );

    sdr_pd_monitor #(.PD_LIMIT(PD_LIMIT)) u_pd (
        .clk      (clk),
        .rst      (rst),
        .enter_req(pd_enter),
        .cke      (cke),
        .any_open (|bank_open),
        .pd_on    (pd_on),
        .pd_kind  (pd_active_kind),
        .overlong (err_pd_overlong)
    );

    assign err_idle_access = err_q.idle;
    assign err_early_act   = err_q.early;
endmodule

// File: rtl/sdr_bank_tracker_chk.sv
module sdr_bank_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       cke,
    input logic       a10,
    input logic [1:0] ba,
    input logic       dqm,
    input logic [3:0] bank_open,
    input logic       pd_on,
    input logic       pd_active_kind,
    input logic       wr_commit,
    input logic       err_idle_access,
    input logic       err_early_act,
    input logic       err_pd_overlong
);
    // R4
    pre_all_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (!pd_on && !cs_n && !ras_n && cas_n && !we_n && a10) |=> (bank_open == 4'b0000));

    // R6
    idle_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        err_idle_access |-> $past(!pd_on && !cs_n && ras_n && !cas_n));

    // R7
    early_no_open_chk: assert property (@(posedge clk) disable iff (rst)
        err_early_act |-> ((bank_open & ~$past(bank_open)) == 4'b0000));

    // R8
    pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        pd_on |-> (!wr_commit && !err_idle_access && !err_early_act));

    // R10
    pd_exit_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pd_on) |-> (bank_open == $past(bank_open)));

    // R11
    overlong_only_pd_chk: assert property (@(posedge clk) disable iff (rst)
        !pd_on |-> !err_pd_overlong);
endmodule

bind sdr_bank_tracker sdr_bank_tracker_chk u_chk (.*);

// File: tb/sdr_bank_tracker_test.sv
module sdr_bank_tracker_test;
    localparam logic [3:0] C_INH = 4'b1111;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_BST = 4'b0110;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam int LIMIT = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic cke = 1'b1, a10 = 1'b0, dqm = 1'b1;
    logic [1:0] ba = 2'd0;
    logic [3:0] bank_open;
    logic pd_on, pd_active_kind, wr_commit;
    logic err_idle_access, err_early_act, err_pd_overlong;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdr_bank_tracker #(.TRP(3), .BURST_LEN(4), .CLK_MHZ(100), .REFRESH_US(1)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .a10(a10), .ba(ba), .dqm(dqm),
        .bank_open(bank_open), .pd_on(pd_on), .pd_active_kind(pd_active_kind),
        .wr_commit(wr_commit), .err_idle_access(err_idle_access),
        .err_early_act(err_early_act), .err_pd_overlong(err_pd_overlong)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] c, input logic a, input logic [1:0] b,
                        input logic k, input logic m);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = c;
        a10 = a; ba = b; cke = k; dqm = m;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk("R2 bank_open", 32'(bank_open), 32'h0);
        chk("R2 pd_on", 32'(pd_on), 32'h0);
        chk("R2 flags", 32'({wr_commit, err_idle_access, err_early_act, err_pd_overlong}), 32'h0);
    endtask

    task automatic t_activate;
        step(C_ACT, 1'b0, 2'd0, 1'b1, 1'b1);
        chk("R3 R1 activate bank0", 32'(bank_open), 32'h1);
    endtask

    task automatic t_pre_single;
        step(C_ACT, 1'b0, 2'd1, 1'b1, 1'b1);
        step(C_ACT, 1'b0, 2'd2, 1'b1, 1'b1);
        chk("R3 three open", 32'(bank_open), 32'h7);
        step(C_PRE, 1'b0, 2'd1, 1'b1, 1'b1);
        chk("R5 single precharge", 32'(bank_open), 32'h5);
    endtask

    task automatic t_pre_all;
        step(C_PRE, 1'b1, 2'd1, 1'b1, 1'b1);
        chk("R4 all precharge ba ignored", 32'(bank_open), 32'h0);
    endtask

    task automatic t_trp;
        step(C_ACT, 1'b0, 2'd0, 1'b1, 1'b1);
        chk("R7 early flag", 32'(err_early_act), 32'h1);
        chk("R7 early stays closed", 32'(bank_open), 32'h0);
        step(C_NOP, 1'b0, 2'd0, 1'b1, 1'b1);
        chk("R7 flag is one pulse", 32'(err_early_act), 32'h0);
        step(C_ACT, 1'b0, 2'd0, 1'b1, 1'b1);
        chk("R7 accepted at TRP", 32'(bank_open), 32'h1);
        chk("R7 no flag at TRP", 32'(err_early_act), 32'h0);
    endtask

    task automatic t_idle_access;
        step(C_RD, 1'b0, 2'd3, 1'b1, 1'b1);
        chk("R6 read idle bank", 32'(err_idle_access), 32'h1);
        step(C_RD, 1'b0, 2'd0, 1'b1, 1'b1);
        chk("R6 read open bank", 32'(err_idle_access), 32'h0);
        step(C_WR, 1'b0, 2'd2, 1'b1, 1'b0);
        chk("R6 write idle bank", 32'(err_idle_access), 32'h1);
        chk("R6 idle write not committed", 32'(wr_commit), 32'h0);
    endtask

    task automatic t_write;
        step(C_WR, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R12 beat0", 32'(wr_commit), 32'h1);
        step(C_NOP, 1'b0, 2'd0, 1'b1, 1'b1);
        chk("R12 beat1 masked", 32'(wr_commit), 32'h0);
        step(C_NOP, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R12 beat2", 32'(wr_commit), 32'h1);
        step(C_NOP, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R12 beat3", 32'(wr_commit), 32'h1);
        step(C_NOP, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R12 after burst", 32'(wr_commit), 32'h0);
    endtask

    task automatic t_bst;
        step(C_WR, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R13 beat0", 32'(wr_commit), 32'h1);
        step(C_NOP, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R13 beat1 last written", 32'(wr_commit), 32'h1);
        step(C_BST, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R13 terminate cycle dropped", 32'(wr_commit), 32'h0);
        step(C_NOP, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R13 burst ended", 32'(wr_commit), 32'h0);
    endtask

    task automatic t_pd_blocked;
        step(C_WR, 1'b0, 2'd0, 1'b1, 1'b0);
        step(C_NOP, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R8 no entry during burst", 32'(pd_on), 32'h0);
        chk("R8 beat still written", 32'(wr_commit), 32'h1);
        step(C_NOP, 1'b0, 2'd0, 1'b1, 1'b1);
        step(C_NOP, 1'b0, 2'd0, 1'b1, 1'b1);
    endtask

    task automatic t_pd_active;
        step(C_NOP, 1'b0, 2'd0, 1'b0, 1'b1);
        chk("R8 entry", 32'(pd_on), 32'h1);
        chk("R9 active kind", 32'(pd_active_kind), 32'h1);
        step(C_PRE, 1'b1, 2'd0, 1'b0, 1'b1);
        chk("R8 precharge ignored", 32'(bank_open), 32'h1);
        step(C_RD, 1'b0, 2'd3, 1'b0, 1'b1);
        chk("R8 idle read ignored", 32'(err_idle_access), 32'h0);
        step(C_NOP, 1'b0, 2'd0, 1'b1, 1'b1);
        chk("R10 exit", 32'(pd_on), 32'h0);
        chk("R10 banks kept", 32'(bank_open), 32'h1);
    endtask

    task automatic t_pd_precharge;
        step(C_PRE, 1'b1, 2'd0, 1'b1, 1'b1);
        step(C_INH, 1'b0, 2'd0, 1'b0, 1'b1);
        chk("R8 entry on inhibit", 32'(pd_on), 32'h1);
        chk("R9 precharge kind", 32'(pd_active_kind), 32'h0);
        for (int i = 0; i < LIMIT - 1; i++) begin
            step(C_NOP, 1'b0, 2'd0, 1'b0, 1'b1);
        end
        chk("R11 at limit no flag", 32'(err_pd_overlong), 32'h0);
        step(C_NOP, 1'b0, 2'd0, 1'b0, 1'b1);
        chk("R11 beyond limit flag", 32'(err_pd_overlong), 32'h1);
        step(C_NOP, 1'b0, 2'd0, 1'b1, 1'b1);
        chk("R11 flag cleared on exit", 32'(err_pd_overlong), 32'h0);
        chk("R10 exit after long pd", 32'(pd_on), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_activate();
        t_pre_single();
        t_pre_all();
        t_trp();
        t_idle_access();
        t_write();
        t_bst();
        t_pd_blocked();
        t_pd_active();
        t_pd_precharge();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule